// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block takes a dual-output digital voltage regulator from reset to regulation. It first waits for the controller supply to become good. It then enables the internal core regulator and asks for a self-check. After that it asks for the user configuration chosen by a strap input to be loaded, and it fires a single strobe that starts telemetry. Only then does it compare the digitized input voltage against a programmable rising lockout threshold. Once that threshold is met, the controller sits in a shutdown state. The PWM pins of every rail are held high-impedance, and each rail waits for its own enable.

When a rail is enabled, it waits a programmable number of clock-enable ticks. It then ramps its soft-start reference linearly to a target code over a programmable number of ticks. The ramp adds a fixed step on each tick, and the last tick lands exactly on the target. Dropping a rail's enable returns that rail to shutdown. An input voltage falling below the lower, falling threshold returns every rail to shutdown. If the configuration load never finishes, a timeout latches a fault that holds until reset.

The self-check, the configuration memory, the ADC and the control loop lie outside the block. They are reached through simple request/done signals and through the sampled input code.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While the supply-good input has never been high since reset, the core enable, the self-check request, the config-load request, the telemetry strobe and all PWM output enables stay low.
- R2: The core enable rises on the first clock after supply-good is sampled high, and it stays high until reset.
- R3: The self-check request is held until self-check done is sampled. The config-load request then follows and is held until config done. The two are never high together. The strap value present when supply-good is first sampled is latched onto `cfg_slot`.
- R4: After config done, `telem_start` is high for exactly one cycle, and it comes before any input-voltage comparison takes place.
- R5: The input-voltage comparison is enabled only after the telemetry strobe. The controller becomes ready one cycle after `vin_code >= vin_rise` has been registered.
- R6: Once ready, the controller stays ready while `vin_code` lies between `vin_fall` and `vin_rise`. It leaves ready only when `vin_code < vin_fall`.
- R7: Rail enables have no effect until the controller is ready. After that, a rail with its enable high leaves shutdown.
- R8: A rail's PWM output enable is low in shutdown and during the delay, and high during the ramp and after it. While it is low, that rail's reference is zero.
- R9: A rail waits `delay_ticks` tick pulses after leaving shutdown, then begins its ramp. A delay of 0 costs one clock.
- R10: During the ramp, each tick adds floor(target / ramp_ticks) to the reference. On the tick that completes `ramp_ticks` ticks, the reference is set to the target exactly. With `ramp_ticks` = 0, the first tick jumps straight to the target. The reference never exceeds the target.
- R11: Dropping a rail's enable, or an input voltage below `vin_fall`, returns the affected rail to shutdown. Its PWM output enable goes low and its reference goes to zero.
- R12: If config done is not seen within `CFG_TIMEOUT` cycles of the config-load request, `cfg_fault` latches high until reset. No rail is ever enabled while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_good | input | 1 | Controller supply above its rising threshold |
| cfg_sel | input | SEL_W | Strap selection of the configuration slot |
| selftest_done | input | 1 | Self-check finished |
| cfg_done | input | 1 | Configuration load finished |
| vin_code | input | VIN_W | Digitized input voltage |
| vin_rise | input | VIN_W | Rising lockout threshold |
| vin_fall | input | VIN_W | Falling lockout threshold (at or below rising) |
| tick | input | 1 | Soft-start clock enable |
| rail_en | input | N_RAILS | Per-rail enable |
| delay_ticks | input | N_RAILS*CNT_W | Per-rail delay in ticks |
| ramp_ticks | input | N_RAILS*CNT_W | Per-rail ramp length in ticks |
| ref_target | input | N_RAILS*REF_W | Per-rail target reference code |
| ldo_en | output | 1 | Internal core regulator enable |
| selftest_req | output | 1 | Self-check request |
| cfg_req | output | 1 | Configuration load request |
| cfg_slot | output | SEL_W | Latched configuration slot |
| telem_start | output | 1 | One-cycle telemetry start strobe |
| cfg_fault | output | 1 | Sticky config-load timeout fault |
| pwm_oe | output | N_RAILS | Per-rail PWM drive enable (low = high-impedance) |
| ref_code | output | N_RAILS*REF_W | Per-rail soft-start reference |

## Verification
The bench raises both rail enables long before the lockout test passes. A design that honours them early would switch into an unqualified input supply. It sits the input voltage between the two thresholds, where a comparator without hysteresis would drop the rails. It uses a target that the tick count does not divide evenly, so a ramp that only accumulates steps would stop short of the target. It also covers a zero-tick ramp and a zero-tick delay, where off-by-one counters hang or overshoot. Finally, it withholds config done for the timeout test, and then raises it late to show that the fault does not clear.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      G_OFF,
      G_CHECK,
      G_CFG,
      G_TELEM,
      G_VINWAIT,
      G_READY,
      G_FAIL
   } gstate_t;

   typedef enum logic [1:0] {
      R_SHUT,
      R_DELAY,
      R_RAMP,
      R_ON
   } rstate_t;

endpackage

// File: rtl/pwr_seq_init.sv
module pwr_seq_init
   import pwr_seq_pkg::*;
#(
   parameter int CFG_TIMEOUT = 1024,
   parameter int SEL_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vcc_good,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic             selftest_done,
   input  logic             cfg_done,
   input  logic             vin_ok,
   output logic             ldo_en,
   output logic             selftest_req,
   output logic             cfg_req,
   output logic             telem_start,
   output logic             cmp_en,
   output logic             sys_ready,
   output logic             cfg_fault,
   output logic [SEL_W-1:0] cfg_slot
);
   localparam int TO_W = $clog2(CFG_TIMEOUT + 1);
   localparam logic [TO_W-1:0] TO_LAST = TO_W'(CFG_TIMEOUT - 1);

   gstate_t          st_q;
   logic [TO_W-1:0]  to_cnt_q;
   logic [SEL_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= G_OFF;
         to_cnt_q <= '0;
         slot_q   <= '0;
      end else begin
         unique case (st_q)
            G_OFF: if (vcc_good) begin
               st_q   <= G_CHECK;
               slot_q <= cfg_sel;
            end
            G_CHECK: if (selftest_done) begin
               st_q     <= G_CFG;
               to_cnt_q <= '0;
            end
            G_CFG: begin
               if (cfg_done)               st_q <= G_TELEM;
               else if (to_cnt_q == TO_LAST) st_q <= G_FAIL;
               else                        to_cnt_q <= to_cnt_q + TO_W'(1);
            end
            G_TELEM:   st_q <= G_VINWAIT;
            G_VINWAIT: if (vin_ok)  st_q <= G_READY;
            G_READY:   if (!vin_ok) st_q <= G_VINWAIT;
            G_FAIL:    st_q <= G_FAIL;
            default:   st_q <= G_OFF;
         endcase
      end
   end

   assign ldo_en       = (st_q != G_OFF);
   assign selftest_req = (st_q == G_CHECK);
   assign cfg_req      = (st_q == G_CFG);
   assign telem_start  = (st_q == G_TELEM);
   assign cmp_en       = (st_q == G_VINWAIT) || (st_q == G_READY);
   assign sys_ready    = (st_q == G_READY);
   assign cfg_fault    = (st_q == G_FAIL);
   assign cfg_slot     = slot_q;

endmodule

// File: rtl/pwr_seq_uvlo.sv
module pwr_seq_uvlo #(
   parameter int VIN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_en,
   input  logic [VIN_W-1:0] vin_code,
   input  logic [VIN_W-1:0] vin_rise,
   input  logic [VIN_W-1:0] vin_fall,
   output logic             vin_ok
);
   logic ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !cmp_en)         ok_q <= 1'b0;
      else if (vin_code >= vin_rise) ok_q <= 1'b1;
      else if (vin_code < vin_fall)  ok_q <= 1'b0;
   end

   assign vin_ok = ok_q;

endmodule

// File: rtl/pwr_seq_rail.sv
module pwr_seq_rail
   import pwr_seq_pkg::*;
#(
   parameter int REF_W     = 12,
   parameter int CNT_W     = 16,
   parameter bit STEP_PIPE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [CNT_W-1:0] delay_ticks,
   input  logic [CNT_W-1:0] ramp_ticks,
   input  logic [REF_W-1:0] target,
   output logic             pwm_oe,
   output logic [REF_W-1:0] ref_code
);
   localparam int DW = REF_W + CNT_W;

   rstate_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [REF_W-1:0] ref_q;
   logic [REF_W-1:0] step_c;
   logic [REF_W-1:0] step_use;
   logic [CNT_W-1:0] den;
   logic             last_tick;

   assign den    = (ramp_ticks == '0) ? CNT_W'(1) : ramp_ticks;
   assign step_c = REF_W'(DW'(target) / DW'(den));

   generate
      if (STEP_PIPE) begin : g_step_reg
         logic [REF_W-1:0] step_q;
         always_ff @(posedge clk) begin
            if (!rst_n) step_q <= '0;
            else        step_q <= step_c;
         end
         assign step_use = step_q;
      end else begin : g_step_comb
         assign step_use = step_c;
      end
   endgenerate

   assign last_tick = (ramp_ticks == '0) ||
                      ((CNT_W+1)'(cnt_q) + (CNT_W+1)'(1) >= (CNT_W+1)'(ramp_ticks));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= R_SHUT;
         cnt_q <= '0;
         ref_q <= '0;
      end else if (st_q == R_SHUT) begin
         if (run) begin
            st_q  <= R_DELAY;
            cnt_q <= '0;
         end
      end else if (!run) begin
         st_q  <= R_SHUT;
         cnt_q <= '0;
         ref_q <= '0;
      end else begin
         unique case (st_q)
            R_DELAY: begin
               if (cnt_q >= delay_ticks) begin
                  st_q  <= R_RAMP;
                  cnt_q <= '0;
               end else if (tick) begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            R_RAMP: if (tick) begin
               if (last_tick) begin
                  ref_q <= target;
                  st_q  <= R_ON;
               end else begin
                  ref_q <= ref_q + step_use;
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: st_q <= st_q;
         endcase
      end
   end

   assign pwm_oe   = (st_q == R_RAMP) || (st_q == R_ON);
   assign ref_code = ref_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
   parameter int N_RAILS     = 2,
   parameter int REF_W       = 12,
   parameter int VIN_W       = 12,
   parameter int CNT_W       = 16,
   parameter int CFG_TIMEOUT = 1024,
   parameter int SEL_W       = 2,
   parameter bit STEP_PIPE   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vcc_good,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic                     selftest_done,
   input  logic                     cfg_done,
   input  logic [VIN_W-1:0]         vin_code,
   input  logic [VIN_W-1:0]         vin_rise,
   input  logic [VIN_W-1:0]         vin_fall,
   input  logic                     tick,
   input  logic [N_RAILS-1:0]       rail_en,
   input  logic [N_RAILS*CNT_W-1:0] delay_ticks,
   input  logic [N_RAILS*CNT_W-1:0] ramp_ticks,
   input  logic [N_RAILS*REF_W-1:0] ref_target,
   output logic                     ldo_en,
   output logic                     selftest_req,
   output logic                     cfg_req,
   output logic [SEL_W-1:0]         cfg_slot,
   output logic                     telem_start,
   output logic                     cfg_fault,
   output logic [N_RAILS-1:0]       pwm_oe,
   output logic [N_RAILS*REF_W-1:0] ref_code
);
   generate
      if (N_RAILS < 1)     begin : g_bad_rails   $error("N_RAILS must be at least 1"); end
      if (REF_W < 2)       begin : g_bad_ref     $error("REF_W must be at least 2"); end
      if (CNT_W < 1)       begin : g_bad_cnt     $error("CNT_W must be at least 1"); end
      if (VIN_W < 1)       begin : g_bad_vin     $error("VIN_W must be at least 1"); end
      if (CFG_TIMEOUT < 2) begin : g_bad_timeout $error("CFG_TIMEOUT must be at least 2"); end
      if (SEL_W < 1)       begin : g_bad_sel     $error("SEL_W must be at least 1"); end
   endgenerate

   logic vin_ok;
   logic cmp_en;
   logic sys_ready;

   pwr_seq_init #(
      .CFG_TIMEOUT (CFG_TIMEOUT),
      .SEL_W       (SEL_W)
   ) u_init (
      .clk           (clk),
      .rst_n         (rst_n),
      .vcc_good      (vcc_good),
      .cfg_sel       (cfg_sel),
      .selftest_done (selftest_done),
      .cfg_done      (cfg_done),
      .vin_ok        (vin_ok),
      .ldo_en        (ldo_en),
      .selftest_req  (selftest_req),
      .cfg_req       (cfg_req),
      .telem_start   (telem_start),
      .cmp_en        (cmp_en),
      .sys_ready     (sys_ready),
      .cfg_fault     (cfg_fault),
      .cfg_slot      (cfg_slot)
   );

   pwr_seq_uvlo #(
      .VIN_W (VIN_W)
   ) u_uvlo (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_en   (cmp_en),
      .vin_code (vin_code),
      .vin_rise (vin_rise),
      .vin_fall (vin_fall),
      .vin_ok   (vin_ok)
   );

   for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
      pwr_seq_rail #(
         .REF_W     (REF_W),
         .CNT_W     (CNT_W),
         .STEP_PIPE (STEP_PIPE)
      ) u_rail (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick        (tick),
         .run         (sys_ready & rail_en[i]),
         .delay_ticks (delay_ticks[i*CNT_W +: CNT_W]),
         .ramp_ticks  (ramp_ticks[i*CNT_W +: CNT_W]),
         .target      (ref_target[i*REF_W +: REF_W]),
         .pwm_oe      (pwm_oe[i]),
         .ref_code    (ref_code[i*REF_W +: REF_W])
      );
   end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int N_RAILS = 2,
   parameter int REF_W   = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ldo_en,
   input logic                     selftest_req,
   input logic                     cfg_req,
   input logic                     telem_start,
   input logic                     cfg_fault,
   input logic [N_RAILS-1:0]       rail_en,
   input logic [N_RAILS-1:0]       pwm_oe,
   input logic [N_RAILS*REF_W-1:0] ref_code,
   input logic [N_RAILS*REF_W-1:0] ref_target
);
   // R1
   quiet_before_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ldo_en |-> (!selftest_req && !cfg_req && !telem_start && pwm_oe == '0));

   // R2
   core_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ldo_en |=> ldo_en);

   // R3
   req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(selftest_req && cfg_req));

   // R4
   telem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      telem_start |=> !telem_start);

   // R12
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fault |=> (cfg_fault && pwm_oe == '0));

   for (genvar i = 0; i < N_RAILS; i++) begin : g_rail_chk
      // R8
      hiz_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pwm_oe[i] |-> (ref_code[i*REF_W +: REF_W] == '0));

      // R11
      en_drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(rail_en[i]) |=> !pwm_oe[i]);

      // R10
      ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ref_code[i*REF_W +: REF_W] <= ref_target[i*REF_W +: REF_W]);
   end

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
   .N_RAILS (N_RAILS),
   .REF_W   (REF_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ldo_en       (ldo_en),
   .selftest_req (selftest_req),
   .cfg_req      (cfg_req),
   .telem_start  (telem_start),
   .cfg_fault    (cfg_fault),
   .rail_en      (rail_en),
   .pwm_oe       (pwm_oe),
   .ref_code     (ref_code),
   .ref_target   (ref_target)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
   localparam int NR = 2;
   localparam int RW = 12;
   localparam int VW = 12;
   localparam int CW = 8;
   localparam int TO = 40;
   localparam int SW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             vcc_good = 1'b0;
   logic [SW-1:0]    cfg_sel = '0;
   logic             selftest_done = 1'b0;
   logic             cfg_done = 1'b0;
   logic [VW-1:0]    vin_code = '0;
   logic [VW-1:0]    vin_rise = '0;
   logic [VW-1:0]    vin_fall = '0;
   logic             tick = 1'b0;
   logic [NR-1:0]    rail_en = '0;
   logic [NR*CW-1:0] delay_ticks = '0;
   logic [NR*CW-1:0] ramp_ticks = '0;
   logic [NR*RW-1:0] ref_target = '0;
   logic             ldo_en, selftest_req, cfg_req, telem_start, cfg_fault;
   logic [SW-1:0]    cfg_slot;
   logic [NR-1:0]    pwm_oe;
   logic [NR*RW-1:0] ref_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   pwr_seq_ctrl #(
      .N_RAILS(NR), .REF_W(RW), .VIN_W(VW), .CNT_W(CW),
      .CFG_TIMEOUT(TO), .SEL_W(SW), .STEP_PIPE(1'b1)
   ) u_pwr_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .vcc_good(vcc_good), .cfg_sel(cfg_sel),
      .selftest_done(selftest_done), .cfg_done(cfg_done),
      .vin_code(vin_code), .vin_rise(vin_rise), .vin_fall(vin_fall),
      .tick(tick), .rail_en(rail_en), .delay_ticks(delay_ticks),
      .ramp_ticks(ramp_ticks), .ref_target(ref_target),
      .ldo_en(ldo_en), .selftest_req(selftest_req), .cfg_req(cfg_req),
      .cfg_slot(cfg_slot), .telem_start(telem_start), .cfg_fault(cfg_fault),
      .pwm_oe(pwm_oe), .ref_code(ref_code)
   );

   // reference model: 0 off,1 check,2 cfg,3 telem,4 vinwait,5 ready,6 fail
   int m_g, m_cnt, m_slot, m_vok;
   int m_rs [NR];
   int m_rc [NR];
   int m_ref[NR];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_g = 0; m_cnt = 0; m_slot = 0; m_vok = 0;
         for (int i = 0; i < NR; i++) begin m_rs[i] = 0; m_rc[i] = 0; m_ref[i] = 0; end
      end else begin
         int ng, nv, dly, rmp, tgt;
         bit rdy;
         ng  = m_g;
         rdy = (m_g == 5);
         case (m_g)
            0: if (vcc_good) begin ng = 1; m_slot = int'(cfg_sel); end
            1: if (selftest_done) begin ng = 2; m_cnt = 0; end
            2: if (cfg_done) ng = 3;
               else if (m_cnt == TO - 1) ng = 6;
               else m_cnt++;
            3: ng = 4;
            4: if (m_vok != 0) ng = 5;
            5: if (m_vok == 0) ng = 4;
            default: ;
         endcase
         if (!(m_g == 4 || m_g == 5)) nv = 0;
         else if (vin_code >= vin_rise) nv = 1;
         else if (vin_code < vin_fall) nv = 0;
         else nv = m_vok;
         for (int i = 0; i < NR; i++) begin
            dly = int'(delay_ticks[i*CW +: CW]);
            rmp = int'(ramp_ticks[i*CW +: CW]);
            tgt = int'(ref_target[i*RW +: RW]);
            if (m_rs[i] == 0) begin
               if (rdy && rail_en[i]) begin m_rs[i] = 1; m_rc[i] = 0; end
            end else if (!(rdy && rail_en[i])) begin
               m_rs[i] = 0; m_rc[i] = 0; m_ref[i] = 0;
            end else if (m_rs[i] == 1) begin
               if (m_rc[i] >= dly) begin m_rs[i] = 2; m_rc[i] = 0; end
               else if (tick) m_rc[i]++;
            end else if (m_rs[i] == 2 && tick) begin
               if (rmp == 0 || m_rc[i] + 1 >= rmp) begin m_ref[i] = tgt; m_rs[i] = 3; end
               else begin m_ref[i] += tgt / rmp; m_rc[i]++; end
            end
         end
         m_g = ng; m_vok = nv;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (!done) begin
         check("R2 ldo_en",       int'(ldo_en),       int'(m_g != 0));
         check("R3 selftest_req", int'(selftest_req), int'(m_g == 1));
         check("R3 cfg_req",      int'(cfg_req),      int'(m_g == 2));
         check("R3 cfg_slot",     int'(cfg_slot),     m_slot);
         check("R4 telem_start",  int'(telem_start),  int'(m_g == 3));
         check("R12 cfg_fault",   int'(cfg_fault),    int'(m_g == 6));
         for (int i = 0; i < NR; i++) begin
            check("R8 pwm_oe",  int'(pwm_oe[i]), int'(m_rs[i] >= 2));
            check("R10 ref",    int'(ref_code[i*RW +: RW]), m_ref[i]);
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) tick <= ~tick;
      end
   end

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      cfg_sel    = 2'd2;
      vin_code   = 12'd100;
      vin_rise   = 12'd800;
      vin_fall   = 12'd600;
      delay_ticks = {8'd0, 8'd3};
      ramp_ticks  = {8'd4, 8'd5};
      ref_target  = {12'd1001, 12'd1000};
      rail_en    = 2'b11;
      cycles(4);
      check("R1 reset ldo_en", int'(ldo_en), 0);
      rst_n = 1'b1;
      cycles(5);
      check("R1 no start without supply", int'({ldo_en, selftest_req, cfg_req, pwm_oe}), 0);
      vcc_good = 1'b1;
      cycles(3);
      check("R3 selftest requested", int'(selftest_req), 1);
      selftest_done = 1'b1;
      cycles(4);
      check("R3 cfg requested", int'(cfg_req), 1);
      check("R3 slot latched", int'(cfg_slot), 2);
      cfg_done = 1'b1;
      cycles(10);
      check("R7 enables ignored before ready", int'(pwm_oe), 0);
      check("R5 ref held low below rise", int'(ref_code), 0);
      vin_code = 12'd900;
      cycles(60);
      check("R10 rail0 reaches target", int'(ref_code[0 +: RW]), 1000);
      check("R10 rail1 clamped on target", int'(ref_code[RW +: RW]), 1001);
      check("R8 both rails driving", int'(pwm_oe), 3);
      vin_code = 12'd700;
      cycles(5);
      check("R6 hysteresis holds rails", int'(pwm_oe), 3);
      rail_en = 2'b10;
      cycles(3);
      check("R11 rail0 off after enable drop", int'(pwm_oe), 2);
      check("R11 rail0 ref zero", int'(ref_code[0 +: RW]), 0);
      rail_en = 2'b11;
      cycles(4);
      vin_code = 12'd500;
      cycles(4);
      check("R11 undervoltage shuts rails", int'(pwm_oe), 0);
      check("R11 undervoltage refs zero", int'(ref_code), 0);
      vin_code = 12'd900;
      cycles(30);
      rail_en = 2'b00;
      cycles(3);
      delay_ticks = {8'd0, 8'd0};
      ramp_ticks  = {8'd4, 8'd0};
      rail_en = 2'b01;
      cycles(10);
      check("R10 zero ramp jumps to target", int'(ref_code[0 +: RW]), 1000);
      check("R9 zero delay rail active", int'(pwm_oe), 1);
      rst_n = 1'b0;
      cfg_done = 1'b0;
      cycles(3);
      rst_n = 1'b1;
      cycles(TO + 15);
      check("R12 timeout fault set", int'(cfg_fault), 1);
      check("R12 rails stay off", int'(pwm_oe), 0);
      cfg_done = 1'b1;
      cycles(5);
      check("R12 fault sticky", int'(cfg_fault), 1);
      check("R12 no late config request", int'(cfg_req), 0);
      finish_run();
   end

endmodule